// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Execution Unit

This unit executes a single register-to-register multiply-accumulate instruction for a 32-bit load/store processor. The pipeline hands it the raw instruction word together with the three register values read for the source fields and the destination field. The unit checks the encoding itself. On a match it multiplies the signed low halves of the two source values and adds the 32-bit product to the old destination value. It then returns the sum with a write-enable and the destination index, ready for the register file.

The product is formed by a radix-2 shift-add engine that spends one clock per multiplier bit, so an operation occupies the unit for 16 cycles. The caller raises `start` for one cycle. It watches `busy`, and takes the result on the one-cycle `done` pulse. The adder chain is seeded with the destination value, so the accumulate step costs no extra cycle.

Top module: `mac_unit`

## Requirements
- R1: An instruction is accepted only when bits 31:26 equal 000000 and bits 5:0 equal 000101. Any other word presented with `start` leaves `busy`, `done` and `wr_en` low.
- R2: The source fields are bits 25:21 and 20:16, and the destination field is bits 15:11. `wr_idx` shows the destination field of the accepted instruction during the `done` cycle.
- R3: `result` equals the destination value plus the product of source-A bits 15:0 and source-B bits 15:0, taken modulo 2^32. Bits 31:16 of both source values have no effect.
- R4: Both 16-bit operands are two's-complement signed values. The sum wraps around, with no saturation and no trap.
- R5: After an accepting clock edge, `busy` is high for exactly 16 cycles. `done` is then high for exactly one cycle, the cycle in which `busy` has fallen, and `busy` and `done` are never high together.
- R6: Operand values and the instruction word are captured at the accepting edge. A `start`, or any change of the inputs, while `busy` is high has no effect on the running operation or its result.
- R7: When the destination field is 0, `wr_en` stays low during `done`, but `result` still carries the computed value.
- R8: While `rst_n` is low at a clock edge, the unit returns to idle, with `busy`, `done` and `wr_en` low and `result` zero.
- R9: `wr_en` is high only in the `done` cycle. `result` holds its value from `done` until the next accepting edge.
- R10: A `start` in the `done` cycle is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to execute `instr` |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| rd_val | input | 32 | Current value of the destination register (addend) |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | 32 | Accumulated value |
| wr_en | output | 1 | Register write-enable, valid with `done` |
| wr_idx | output | 5 | Destination register index |

## Verification
The assertions assume that `start` and `rst_n` are driven to known values from the first clock edge. They also assume the caller gives no meaning to `result` while `busy` is high, because the partial sum is visible there. The stimulus changes every input only on the falling clock edge, and it keeps `rst_n` low over several edges before the first instruction. It also deliberately toggles `start` and the operand values during a run, and it drops reset in the middle of one. Each of these lies within the contract the checker assumes, since a restart or an ignored request is legal behaviour rather than a protocol breach.

// File: rtl/mac_pkg.sv
// Package: shared encodings and the state type for the multiply-accumulate unit.
// Assumes the standard 32-bit register-format instruction layout.
package mac_pkg;
    localparam logic [5:0] OPC_REG = 6'b000000;
    localparam logic [5:0] FN_MAC  = 6'b000101;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;
endpackage

// File: rtl/mac_decode.sv
// Module: mac_decode
// Recognises the multiply-accumulate encoding and extracts the destination
// field. Purely combinational; assumes a 32-bit register-format word.
module mac_decode
    import mac_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic [XLEN-1:0]  instr,
    output logic             hit,
    output logic [IDX_W-1:0] dst_idx
);
    localparam int OPC_LSB = XLEN - 6;
    localparam int DST_LSB = 11;

    // Match primary opcode and function field, and pull out the destination.
    always_comb begin
        hit     = (instr[XLEN-1:OPC_LSB] == OPC_REG) && (instr[5:0] == FN_MAC);
        dst_idx = instr[DST_LSB +: IDX_W];
    end
endmodule

// File: rtl/mac_seqmul.sv
// Module: mac_seqmul
// Radix-2 shift-add signed multiplier with an addend preloaded into the
// accumulator. One multiplier bit is consumed per clock. The sign bit carries
// a negative weight and is subtracted on the last step. Assumes load is
// asserted only while idle.
module mac_seqmul
    import mac_pkg::*;
#(
    parameter int W    = 16,
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    op_a,
    input  logic [W-1:0]    op_b,
    input  logic [XLEN-1:0] addend,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] acc
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    eng_state_t      state;
    logic [CNT_W-1:0] step;
    logic [XLEN-1:0] mcand;
    logic [W-1:0]    mplier;
    logic [XLEN-1:0] term;
    logic            last_step;

    // Select the partial product for the current multiplier bit.
    always_comb begin
        term      = mplier[0] ? mcand : '0;
        last_step = (step == LAST);
    end

    // Sequence the load, the W add/subtract steps and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            step   <= '0;
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ENG_IDLE) begin
                if (load) begin
                    state  <= ENG_RUN;
                    step   <= '0;
                    mcand  <= {{(XLEN-W){op_a[W-1]}}, op_a};
                    mplier <= op_b;
                    acc    <= addend;
                end
            end else begin
                acc    <= last_step ? (acc - term) : (acc + term);
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                step   <= step + 1'b1;
                if (last_step) begin
                    state <= ENG_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

    // Busy is the running state.
    always_comb busy = (state == ENG_RUN);
endmodule

// File: rtl/mac_unit.sv
// Module: mac_unit (top)
// Executes one multiply-accumulate instruction: dst = dst + a[15:0]*b[15:0],
// signed, wrapping. Decodes its own encoding, runs a sequential multiplier
// and returns the write-back triple. Assumes the register values are valid
// in the cycle start is high.
module mac_unit
    import mac_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OP_W  = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [XLEN-1:0]  instr,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [XLEN-1:0]  rd_val,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  result,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx
);
    logic             hit;
    logic [IDX_W-1:0] dec_idx;
    logic             accept;
    logic             wr_ok;

    mac_decode #(.XLEN(XLEN), .IDX_W(IDX_W)) u_dec (
        .instr   (instr),
        .hit     (hit),
        .dst_idx (dec_idx)
    );

    // Accept a request only when it decodes and the engine is free.
    always_comb accept = start && hit && !busy;

    mac_seqmul #(.W(OP_W), .XLEN(XLEN)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .op_a   (rs_val[OP_W-1:0]),
        .op_b   (rt_val[OP_W-1:0]),
        .addend (rd_val),
        .busy   (busy),
        .done   (done),
        .acc    (result)
    );

    // Capture the destination index and whether it may be written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            wr_ok  <= 1'b0;
        end else if (accept) begin
            wr_idx <= dec_idx;
            wr_ok  <= (dec_idx != '0);
        end
    end

    // Write-enable rides on the done pulse.
    always_comb wr_en = done && wr_ok;
endmodule

// File: rtl/mac_unit_chk.sv
// Module: mac_unit_chk
// Protocol checker for mac_unit, attached by bind. Assumes start and rst_n
// are known from the first edge.
module mac_unit_chk #(
    parameter int XLEN  = 32,
    parameter int OP_W  = 16,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [XLEN-1:0]  instr,
    input logic             busy,
    input logic             done,
    input logic [XLEN-1:0]  result,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx
);
    localparam int RUN_W = $clog2(OP_W + 2) + 1;
    logic [RUN_W-1:0] run_len;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R5
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R5
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RUN_W'(OP_W)));
    // R5
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
    // R1
    start_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && ($past(instr[31:26]) == 6'b000000)
                         && ($past(instr[5:0]) == 6'b000101)));
    // R7
    zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx != '0));
    // R9
    wr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(result));
    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !wr_en && (result == '0)));
endmodule

bind mac_unit mac_unit_chk #(.XLEN(XLEN), .OP_W(OP_W), .IDX_W(IDX_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .instr  (instr),
    .busy   (busy),
    .done   (done),
    .result (result),
    .wr_en  (wr_en),
    .wr_idx (wr_idx)
);

// File: tb/tb_mac_unit.sv
// Bench for mac_unit: behavioural reference model compared on every clock.
module tb_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0, rs_val = '0, rt_val = '0, rd_val = '0;
    logic        busy, done, wr_en;
    logic [31:0] result;
    logic [4:0]  wr_idx;

    int vectors = 0, miscompares = 0;
    bit armed = 0;
    string phase = "R8";

    // reference model state
    bit          m_busy = 0, m_done = 0, m_we = 0, p_we = 0;
    int          m_cnt = 0;
    logic [31:0] m_res = '0, p_res = '0;
    logic [4:0]  m_idx = '0, p_idx = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    mac_unit dut (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
                  .rs_val(rs_val), .rt_val(rt_val), .rd_val(rd_val),
                  .busy(busy), .done(done), .result(result),
                  .wr_en(wr_en), .wr_idx(wr_idx));

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                       input logic [4:0] b, input logic [4:0] d,
                                       input logic [5:0] fn);
        return {op, a, b, d, 5'd0, fn};
    endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        armed = 1;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_we = 0; m_cnt = 0; m_res = '0;
        end else begin
            m_done = 0; m_we = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 16) begin
                    m_busy = 0; m_done = 1; m_res = p_res; m_we = p_we; m_idx = p_idx;
                end
            end else if (start && instr[31:26] == 6'd0 && instr[5:0] == 6'd5) begin
                logic signed [31:0] prod;
                prod   = $signed(rs_val[15:0]) * $signed(rt_val[15:0]);
                p_res  = rd_val + prod;
                p_idx  = instr[15:11];
                p_we   = (instr[15:11] != 5'd0);
                m_busy = 1; m_cnt = 0;
            end
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (armed) begin
            cmp("busy (R5)", {31'd0, busy}, {31'd0, m_busy});
            cmp("done (R5)", {31'd0, done}, {31'd0, m_done});
            cmp("wr_en (R7/R9)", {31'd0, wr_en}, {31'd0, m_we});
            if (!m_busy) cmp("result (R3/R9)", result, m_res);
            if (m_done)  cmp("wr_idx (R2)", {27'd0, wr_idx}, {27'd0, m_idx});
        end
    end

    // Present one request for a cycle, then wait the given number of cycles.
    task automatic issue(input logic [31:0] iw, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] d, input int gap);
        @(negedge clk);
        start = 1; instr = iw; rs_val = a; rt_val = b; rd_val = d;
        @(negedge clk);
        start = 0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] mac_w;
        mac_w = mk(6'd0, 5'd1, 5'd2, 5'd3, 6'd5);
        repeat (4) @(negedge clk);
        @(negedge clk); rst_n = 1;

        phase = "R3"; issue(mac_w, 32'd7, 32'd9, 32'd100, 17);
        phase = "R2"; issue(mk(6'd0, 5'd4, 5'd5, 5'd31, 6'd5), 32'd3, 32'd4, 32'd1, 17);
        phase = "R4"; issue(mac_w, 32'h0000_FFFF, 32'h0000_0005, 32'd10, 17);  // -1*5
        phase = "R4"; issue(mac_w, 32'h0000_8000, 32'h0000_8000, 32'd0, 17);
        phase = "R4"; issue(mac_w, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 17);
        phase = "R4"; issue(mac_w, 32'h0000_7FFF, 32'h0000_8000, 32'h8000_0000, 17);
        phase = "R3"; issue(mac_w, 32'hDEAD_0003, 32'hBEEF_0006, 32'd5, 17);
        phase = "R1"; issue(mk(6'd1, 5'd1, 5'd2, 5'd3, 6'd5), 32'd2, 32'd2, 32'd2, 3);
        phase = "R1"; issue(mk(6'd0, 5'd1, 5'd2, 5'd3, 6'd4), 32'd2, 32'd2, 32'd2, 3);
        phase = "R1"; issue(mk(6'd0, 5'd1, 5'd2, 5'd3, 6'd37), 32'd2, 32'd2, 32'd2, 3);
        phase = "R7"; issue(mk(6'd0, 5'd1, 5'd2, 5'd0, 6'd5), 32'd6, 32'd7, 32'd1, 17);

        // R6: second start and operand changes during a run are ignored.
        phase = "R6"; issue(mac_w, 32'd11, 32'd12, 32'd13, 3);
        issue(mk(6'd0, 5'd1, 5'd2, 5'd9, 6'd5), 32'd99, 32'd99, 32'd99, 2);
        rs_val = 32'h1234_5678; rd_val = 32'hFFFF_0000;
        repeat (12) @(negedge clk);

        // R10: restart in the done cycle.
        phase = "R10"; issue(mac_w, 32'd2, 32'd3, 32'd4, 15);
        issue(mac_w, 32'hFFFF_FFFE, 32'd3, 32'd4, 17);

        // R8: reset in the middle of a run.
        phase = "R8"; issue(mac_w, 32'd5, 32'd5, 32'd5, 6);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        repeat (3) @(negedge clk);

        phase = "R3/R4 sweep";
        for (int i = 0; i < 300; i++) begin
            logic [31:0] iw;
            iw = ($urandom_range(0, 7) == 0) ? $urandom() :
                 mk(6'd0, 5'($urandom()), 5'($urandom()), 5'($urandom()), 6'd5);
            issue(iw, $urandom(), $urandom(), $urandom(), $urandom_range(10, 18));
        end
        repeat (20) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule